// File: doc/BRIEF.md
# Serial Register-Access Slave

This block sits between a host's synchronous serial port and a bank of thirty-two 8-bit configuration registers. The host holds an active-low select line low for the whole transaction and supplies the serial clock. The slave samples input bits on rising clock edges and updates output bits on falling edges. Each transaction opens with an instruction byte. That byte gives the direction, a byte count and a starting address. Between one and four data bytes follow, and the address steps up by one after each byte.

Read data can go back in two ways. In three-wire mode it is driven on the shared data line. In four-wire mode it is driven on a dedicated output line. Bit 7 of register 0 selects the mode, and it resets to three-wire. Pads are not part of this block: each line appears as a value and an output-enable, and the pad ring combines them.

The control state machine has three states. `ST_INSTR` collects the instruction byte. `ST_DATA` moves data bytes. `ST_DONE` ignores any further clocks. It has these transitions:
- `ST_INSTR -> ST_DATA` on the eighth instruction bit.
- `ST_DATA -> ST_DONE` on the last bit of the final counted byte.
- Any state returns to `ST_INSTR` asynchronously whenever the select is high or the reset is asserted.

Top module: `sreg_slave`

## Requirements
- R1: After reset every register reads 0x00, and neither `sdio_oe` nor `sdo_oe` is asserted.
- R2: The instruction byte is received MSB first on rising edges. Bit 7 is the direction (1 = read, 0 = write), bits 6:5 hold the byte count minus one, and bits 4:0 hold the start address.
- R3: Write data bytes arrive MSB first. The transaction writes count+1 bytes to consecutive addresses, and the address wraps from 31 to 0.
- R4: A data byte is committed only once all eight of its bits have been received. If the select rises earlier, the register is left unchanged.
- R5: Clock bits that arrive after the final counted byte have no effect on any register.
- R6: In three-wire mode, read data is driven on `sdio_out` with `sdio_oe` high during the data bytes, MSB first and changing on falling edges. During this time `sdo_oe` stays low.
- R7: In four-wire mode, read data is driven on `sdo` with `sdo_oe` high, and `sdio_oe` stays low.
- R8: After a four-wire read, `sdo` is driven low with `sdo_oe` high from the falling edge that follows the last data bit until the select rises. At that point `sdo_oe` drops.
- R9: During the instruction byte, `sdio_oe` is never asserted.
- R10: Bit 7 of register 0 selects the mode (1 = four-wire). Its reset value is 0, which selects three-wire.
- R11: A high select clears the bit counter, so a transaction that follows an aborted one decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Host serial clock |
| sen_n | input | 1 | Active-low transaction select |
| sdio_in | input | 1 | Shared data line, pad input value |
| sdio_out | output | 1 | Shared data line, value driven on reads |
| sdio_oe | output | 1 | Shared data line output-enable |
| sdo | output | 1 | Dedicated read-data line value |
| sdo_oe | output | 1 | Dedicated read-data line output-enable |
| cfg_q | output | 256 | All register contents; register k occupies bits 8k+7:8k |

## Verification
The hardest cases to reach are the boundaries around the transaction window:
- a select that rises in the middle of a data byte;
- clocks that keep running after the counted bytes are done;
- the low-hold interval between the final falling edge and the rise of the select.

The bench drives these directly. It drops the select after five data bits and then checks that the next transaction still decodes. It sends eight surplus bits after a two-byte write. After a four-wire read, it keeps the select low for an extra clock and samples the dedicated line both before and after releasing the select.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    typedef enum logic [1:0] {
        ST_INSTR = 2'd0,
        ST_DATA  = 2'd1,
        ST_DONE  = 2'd2
    } ser_st_e;
endpackage

// File: rtl/sreg_fsm.sv
module sreg_fsm
    import sreg_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 2,
    parameter int DW     = 8
) (
    input  logic              sclk,
    input  logic              ser_clr,
    input  logic              sdi,
    output ser_st_e           st,
    output logic [2:0]        bit_cnt,
    output logic [ADDR_W-1:0] addr,
    output logic              rd,
    output logic              wr_en,
    output logic [DW-1:0]     wr_data
);
    ser_st_e           st_q, st_d;
    logic [2:0]        bit_q;
    logic [CNT_W-1:0]  byte_q, len_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_q;
    logic [DW-2:0]     sh_q;
    logic [DW-1:0]     byte_w;
    logic              last_bit;

    assign byte_w   = {sh_q, sdi};
    assign last_bit = (bit_q == 3'd7);

    // next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_INSTR: if (last_bit) st_d = ST_DATA;
            ST_DATA:  if (last_bit && byte_q == len_q) st_d = ST_DONE;
            ST_DONE:  st_d = ST_DONE;
            default:  st_d = ST_INSTR;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge sclk or posedge ser_clr) begin
        if (ser_clr) begin
            st_q   <= ST_INSTR;
            bit_q  <= '0;
            byte_q <= '0;
            len_q  <= '0;
            addr_q <= '0;
            rd_q   <= 1'b0;
            sh_q   <= '0;
        end else begin
            st_q <= st_d;
            if (st_q != ST_DONE) begin
                bit_q <= bit_q + 3'd1;
                sh_q  <= byte_w[DW-2:0];
            end
            if (last_bit && st_q == ST_INSTR) begin
                rd_q   <= byte_w[DW-1];
                len_q  <= byte_w[ADDR_W+CNT_W-1:ADDR_W];
                addr_q <= byte_w[ADDR_W-1:0];
                byte_q <= '0;
            end else if (last_bit && st_q == ST_DATA) begin
                addr_q <= addr_q + ADDR_W'(1);
                byte_q <= byte_q + CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        st      = st_q;
        bit_cnt = bit_q;
        addr    = addr_q;
        rd      = rd_q;
        wr_en   = (st_q == ST_DATA) && !rd_q && last_bit;
        wr_data = byte_w;
    end
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank #(
    parameter int ADDR_W = 5,
    parameter int DW     = 8,
    localparam int NREG  = 1 << ADDR_W
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data,
    output logic [NREG*DW-1:0] regs_flat
);
    logic [DW-1:0] mem [NREG];

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[addr] <= wr_data;
        end
    end

    assign rd_data = mem[addr];

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign regs_flat[g*DW +: DW] = mem[g];
    end
endmodule

// File: rtl/sreg_tx.sv
module sreg_tx
    import sreg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          sclk,
    input  logic          ser_clr,
    input  ser_st_e       st,
    input  logic          rd,
    input  logic [2:0]    bit_cnt,
    input  logic [DW-1:0] rd_byte,
    input  logic          mode4,
    output logic          sdio_out,
    output logic          sdio_oe,
    output logic          sdo,
    output logic          sdo_oe
);
    logic bit_d, bit_q, io_oe_d, io_oe_q, so_oe_d, so_oe_q;

    always_comb begin
        bit_d   = 1'b0;
        io_oe_d = 1'b0;
        so_oe_d = 1'b0;
        unique case (st)
            ST_DATA: if (rd) begin
                bit_d   = rd_byte[~bit_cnt];
                io_oe_d = !mode4;
                so_oe_d = mode4;
            end
            ST_DONE: if (rd && mode4) begin
                bit_d   = 1'b0;
                so_oe_d = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(negedge sclk or posedge ser_clr) begin
        if (ser_clr) begin
            bit_q   <= 1'b0;
            io_oe_q <= 1'b0;
            so_oe_q <= 1'b0;
        end else begin
            bit_q   <= bit_d;
            io_oe_q <= io_oe_d;
            so_oe_q <= so_oe_d;
        end
    end

    assign sdio_out = io_oe_q & bit_q;
    assign sdio_oe  = io_oe_q;
    assign sdo      = so_oe_q & bit_q;
    assign sdo_oe   = so_oe_q;
endmodule

// File: rtl/sreg_slave.sv
module sreg_slave
    import sreg_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int CNT_W    = 2,
    parameter int DW       = 8,
    parameter int MODE_REG = 0,
    parameter int MODE_BIT = 7,
    localparam int NREG    = 1 << ADDR_W
) (
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               sen_n,
    input  logic               sdio_in,
    output logic               sdio_out,
    output logic               sdio_oe,
    output logic               sdo,
    output logic               sdo_oe,
    output logic [NREG*DW-1:0] cfg_q
);
    logic              ser_clr;
    ser_st_e           st;
    logic [2:0]        bit_cnt;
    logic [ADDR_W-1:0] addr;
    logic              rd, wr_en, mode4;
    logic [DW-1:0]     wr_data, rd_byte;

    assign ser_clr = sen_n | ~rst_n;
    assign mode4   = cfg_q[MODE_REG*DW + MODE_BIT];

    sreg_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DW(DW)) u_fsm (
        .sclk(sclk), .ser_clr(ser_clr), .sdi(sdio_in), .st(st),
        .bit_cnt(bit_cnt), .addr(addr), .rd(rd), .wr_en(wr_en), .wr_data(wr_data)
    );

    sreg_bank #(.ADDR_W(ADDR_W), .DW(DW)) u_bank (
        .sclk(sclk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_byte), .regs_flat(cfg_q)
    );

    sreg_tx #(.DW(DW)) u_tx (
        .sclk(sclk), .ser_clr(ser_clr), .st(st), .rd(rd), .bit_cnt(bit_cnt),
        .rd_byte(rd_byte), .mode4(mode4), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );
endmodule

// File: rtl/sreg_slave_chk.sv
module sreg_slave_chk
    import sreg_pkg::*;
#(
    parameter int W = 256
) (
    input logic         sclk,
    input logic         rst_n,
    input logic         sen_n,
    input logic         sdio_oe,
    input logic         sdo_oe,
    input logic         mode4,
    input logic [W-1:0] cfg_q,
    input ser_st_e      st
);
    p_float_idle_r8: assert property (@(posedge sclk) disable iff (!rst_n)
        sen_n |-> (!sdio_oe && !sdo_oe));

    p_single_driver_r6: assert property (@(posedge sclk) disable iff (!rst_n)
        !(sdio_oe && sdo_oe));

    p_shared_3w_r6: assert property (@(posedge sclk) disable iff (!rst_n)
        sdio_oe |-> !mode4);

    p_dedicated_4w_r7: assert property (@(posedge sclk) disable iff (!rst_n)
        sdo_oe |-> mode4);

    p_no_write_idle_r4: assert property (@(posedge sclk) disable iff (!rst_n)
        sen_n |=> $stable(cfg_q));

    p_instr_input_r9: assert property (@(posedge sclk) disable iff (!rst_n)
        (st == ST_INSTR) |-> !sdio_oe);
endmodule

bind sreg_slave sreg_slave_chk #(.W(NREG*DW)) u_chk (
    .sclk(sclk), .rst_n(rst_n), .sen_n(sen_n), .sdio_oe(sdio_oe),
    .sdo_oe(sdo_oe), .mode4(mode4), .cfg_q(cfg_q), .st(st)
);

// File: tb/sreg_slave_tb_top.sv
`timescale 1ns/1ps
module sreg_slave_tb_top;
    logic         rst_n = 1'b0;
    logic         sclk  = 1'b0;
    logic         sen_n = 1'b1;
    logic         sdi   = 1'b0;
    logic         sdio_out, sdio_oe, sdo, sdo_oe;
    logic [255:0] cfg_q;

    int           n_checks = 0;
    int           n_errors = 0;
    logic [7:0]   mdl [32];
    logic [7:0]   exp_q [$];
    logic         cap_active = 1'b0;
    logic         cap_pin4   = 1'b0;
    int           mon_bits   = 0;
    logic [7:0]   mon_acc    = 8'h00;

    always #2 sclk = ~sclk;

    sreg_slave dut_i (
        .rst_n(rst_n), .sclk(sclk), .sen_n(sen_n), .sdio_in(sdi),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo), .sdo_oe(sdo_oe),
        .cfg_q(cfg_q)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_instr(input logic rd, input int nb, input logic [4:0] a);
        logic [7:0] ins;
        ins = {rd, 2'(nb - 1), a};
        for (int i = 7; i >= 0; i--) begin
            @(negedge sclk); #1;
            sen_n = 1'b0;
            sdi   = ins[i];
            chk(!sdio_oe, "R9 shared line driven in instruction", {31'd0, sdio_oe}, 0);
        end
    endtask

    task automatic wr(input int nb, input logic [4:0] a, input logic [31:0] wd, input int extra);
        send_instr(1'b0, nb, a);
        for (int k = 0; k < nb; k++) begin
            for (int i = 7; i >= 0; i--) begin
                @(negedge sclk); #1;
                sdi = wd[31 - 8*k - (7 - i)];
            end
            mdl[(int'(a) + k) % 32] = wd[31 - 8*k -: 8];
        end
        for (int e = 0; e < extra; e++) begin
            @(negedge sclk); #1;
            sdi = 1'b1;
        end
        @(negedge sclk); #1;
        sen_n = 1'b1;
        @(negedge sclk); #1;
    endtask

    task automatic rd(input int nb, input logic [4:0] a);
        send_instr(1'b1, nb, a);
        for (int k = 0; k < nb; k++) exp_q.push_back(mdl[(int'(a) + k) % 32]);
        cap_pin4 = mdl[0][7];
        @(negedge sclk); #1;
        cap_active = 1'b1;
        sdi = 1'b0;
        repeat (8*nb - 1) @(negedge sclk);
        @(negedge sclk); #1;
        cap_active = 1'b0;
        if (cap_pin4) begin
            chk(sdo_oe && !sdo, "R8 low hold after final falling edge", {30'd0, sdo_oe, sdo}, 32'h2);
            @(negedge sclk); #1;
            chk(sdo_oe && !sdo, "R8 low hold continues", {30'd0, sdo_oe, sdo}, 32'h2);
        end else begin
            chk(!sdio_oe && !sdo_oe, "R6 lines released after 3-wire read", {30'd0, sdio_oe, sdo_oe}, 0);
        end
        sen_n = 1'b1;
        #1;
        chk(!sdo_oe && !sdio_oe, "R8 float after select rises", {30'd0, sdo_oe, sdio_oe}, 0);
        @(negedge sclk); #1;
    endtask

    task automatic abort_wr(input logic [4:0] a, input int nbits);
        send_instr(1'b0, 1, a);
        for (int i = 0; i < nbits; i++) begin
            @(negedge sclk); #1;
            sdi = 1'b1;
        end
        @(negedge sclk); #1;
        sen_n = 1'b1;
        @(negedge sclk); #1;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge sclk); #2;
            if (cap_active) begin
                if (cap_pin4)
                    chk(sdo_oe && !sdio_oe, "R7 4-wire pin usage", {30'd0, sdo_oe, sdio_oe}, 32'h2);
                else
                    chk(sdio_oe && !sdo_oe, "R6 3-wire pin usage", {30'd0, sdio_oe, sdo_oe}, 32'h2);
                mon_acc  = {mon_acc[6:0], cap_pin4 ? sdo : sdio_out};
                mon_bits = mon_bits + 1;
                if (mon_bits == 8) begin
                    mon_bits = 0;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R2 unexpected read byte", {24'd0, mon_acc}, 0);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(mon_acc == e, cap_pin4 ? "R7 read byte" : "R6 read byte", {24'd0, mon_acc}, {24'd0, e});
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge sclk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge sclk);
        #1;
        chk(cfg_q == '0, "R1 registers zero after reset", cfg_q[31:0], 0);
        chk(!sdio_oe && !sdo_oe, "R1 outputs released in reset", {30'd0, sdio_oe, sdo_oe}, 0);
        rst_n = 1'b1;
        @(negedge sclk); #1;
        chk(cfg_q[7] == 1'b0, "R10 mode resets to 3-wire", {31'd0, cfg_q[7]}, 0);

        rd(4, 5'd0);                                   // R1 zeros via port
        wr(1, 5'd5, 32'hA5000000, 0);                  // R2 R3
        chk(cfg_q[5*8 +: 8] == 8'hA5, "R3 single write", {24'd0, cfg_q[5*8 +: 8]}, 32'hA5);
        rd(1, 5'd5);

        wr(4, 5'd30, 32'h11223344, 0);                 // R3 wrap
        chk(cfg_q[31*8 +: 8] == 8'h22, "R3 burst byte at 31", {24'd0, cfg_q[31*8 +: 8]}, 32'h22);
        chk(cfg_q[1*8 +: 8] == 8'h44, "R3 wrapped byte at 1", {24'd0, cfg_q[1*8 +: 8]}, 32'h44);
        rd(4, 5'd30);

        abort_wr(5'd10, 5);                            // R4
        chk(cfg_q[10*8 +: 8] == 8'h00, "R4 partial byte discarded", {24'd0, cfg_q[10*8 +: 8]}, 0);
        wr(1, 5'd10, 32'h5C000000, 0);                 // R11
        chk(cfg_q[10*8 +: 8] == 8'h5C, "R11 clean decode after abort", {24'd0, cfg_q[10*8 +: 8]}, 32'h5C);

        wr(2, 5'd12, 32'h01020000, 8);                 // R5
        chk(cfg_q[14*8 +: 8] == 8'h00, "R5 surplus bits ignored", {24'd0, cfg_q[14*8 +: 8]}, 0);
        rd(3, 5'd12);

        wr(1, 5'd0, 32'h80000000, 0);                  // R10
        chk(cfg_q[7] == 1'b1, "R10 mode bit set", {31'd0, cfg_q[7]}, 1);
        rd(2, 5'd30);                                  // R7 R8
        rd(1, 5'd0);

        wr(1, 5'd0, 32'h00000000, 0);
        chk(cfg_q[7] == 1'b0, "R10 mode bit cleared", {31'd0, cfg_q[7]}, 0);
        rd(1, 5'd5);                                   // R6 again

        repeat (4) @(negedge sclk);
        chk(exp_q.size() == 0, "R2 all expected bytes observed", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule